// File: doc/BRIEF.md
# Multiplier accumulator with preload

This block is a multiply-accumulate datapath for fixed-point filtering and correlation work. Two operands of `OPW` bits each sit in their own input registers, and each register has its own load enable. A four-bit mode word is captured together with whichever operand is being loaded. The mode word holds the signed/unsigned select, a round request, an accumulate enable and a subtract select. From the registered operands the block forms the full double-width product. It can add a rounding one at the top bit of the low half. It then sign-extends or zero-fills the result to the accumulator width, `AW = 2*OPW + GW`.

On a product-load strobe, the accumulator does one of four things:
- takes the product;
- takes the product plus its old contents;
- takes the product minus its old contents;
- takes a full-width preload word from outside, which bypasses the arithmetic.

The accumulator drives three output fields: the guard bits, the high half and the low half of the product range. Everything runs on one clock. Reset is synchronous and active high.

Top module: `mac_preload_top`

## Requirements
- R1: A synchronous reset clears the operand, mode and accumulator registers, so all three output fields read zero after it.
- R2: The output fields are slices of the accumulator: `lsp_o` = bits OPW-1..0, `msp_o` = bits 2*OPW-1..OPW, `ext_o` = bits AW-1..2*OPW.
- R3: With the unsigned mode (`tc_in` captured as 0), the operands are unsigned and the product is zero-filled to AW bits.
- R4: With the signed mode (`tc_in` captured as 1), both operands are two's complement and the product is sign-extended to AW bits.
- R5: A captured `rnd_in` of 1 adds 2^(OPW-1) to the product before it reaches the accumulator; 0 leaves the product unchanged.
- R6: On `ld_p` with `prel` low, captured `acc_in` 1 and `sub_in` 0, the accumulator becomes old accumulator plus product.
- R7: On `ld_p` with `prel` low, captured `acc_in` 1 and `sub_in` 1, the accumulator becomes product minus old accumulator.
- R8: On `ld_p` with `prel` high, the accumulator takes `pre_data`, whatever the captured accumulate and subtract bits are; with `prel` low and `acc_in` captured 0 it takes the product.
- R9: The mode word is captured on any edge where `ld_x` or `ld_y` is high, and holds its value while both are low.
- R10: The accumulator changes only on edges where `ld_p` is high.
- R11: All accumulator arithmetic wraps modulo 2^AW, with no saturation.
- R12: When operands and product load on the same edge, the product uses the operands and mode word that were registered before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_x | input | 1 | Load X operand and mode word |
| ld_y | input | 1 | Load Y operand and mode word |
| ld_p | input | 1 | Update the accumulator |
| x_in | input | OPW | X operand |
| y_in | input | OPW | Y operand |
| tc_in | input | 1 | 1 = two's complement operands, 0 = unsigned |
| rnd_in | input | 1 | Round request |
| acc_in | input | 1 | 1 = accumulate, 0 = plain load |
| sub_in | input | 1 | With accumulate: product minus accumulator |
| prel | input | 1 | Load accumulator from pre_data |
| pre_data | input | AW | Preload word |
| ext_o | output | GW | Guard field of the accumulator |
| msp_o | output | OPW | High product half |
| lsp_o | output | OPW | Low product half |

## Verification
The bench builds the block with OPW = 4 and GW = 3, which gives an 11-bit accumulator. At that size every pair of operands can be swept in each signed and rounding mode, for plain loads and for both accumulate directions. Each accumulate step starts from a preload value that changes from case to case, so the wrap at 2^11 and negative intermediate results are both reached. Directed sequences then cover the timing cases:
- mode capture through one operand strobe only;
- hold while `ld_p` is low;
- operands and product loaded on the same edge.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

    typedef struct packed {
        logic tc;
        logic rnd;
        logic acc;
        logic sub;
    } mac_ctrl_t;

    typedef enum logic [1:0] {
        OP_LOAD    = 2'd0,
        OP_ADD     = 2'd1,
        OP_SUBR    = 2'd2,
        OP_PRELOAD = 2'd3
    } acc_op_t;

    // preload outranks the mode word; accumulate outranks subtract
    function automatic acc_op_t decode_op(input logic prel, input mac_ctrl_t c);
        acc_op_t op;
        if (prel)
            op = OP_PRELOAD;
        else if (!c.acc)
            op = OP_LOAD;
        else if (c.sub)
            op = OP_SUBR;
        else
            op = OP_ADD;
        return op;
    endfunction

endpackage

// File: rtl/mac_in_regs.sv
`timescale 1ns/1ps
module mac_in_regs
    import mac_pkg::*;
#(
    parameter int OPW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_x,
    input  logic            ld_y,
    input  logic [OPW-1:0]  x_in,
    input  logic [OPW-1:0]  y_in,
    input  mac_ctrl_t       ctrl_in,
    output logic [OPW-1:0]  x_q,
    output logic [OPW-1:0]  y_q,
    output mac_ctrl_t       ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            ctrl_q <= '0;
        end else begin
            if (ld_x)
                x_q <= x_in;
            if (ld_y)
                y_q <= y_in;
            if (ld_x || ld_y)
                ctrl_q <= ctrl_in;
        end
    end

endmodule

// File: rtl/mac_product.sv
`timescale 1ns/1ps
module mac_product #(
    parameter int OPW = 16,
    parameter int GW  = 3,
    localparam int AW = 2*OPW + GW
) (
    input  logic [OPW-1:0] x_q,
    input  logic [OPW-1:0] y_q,
    input  logic           tc,
    input  logic           rnd,
    output logic [AW-1:0]  prod
);

    localparam int XW = AW - OPW;

    logic [AW-1:0] x_ext;
    logic [AW-1:0] y_ext;
    logic [AW-1:0] mul;
    logic [AW-1:0] rnd_term;

    // extend both operands to full width; truncated product is exact mod 2^AW
    always_comb begin
        x_ext = tc ? {{XW{x_q[OPW-1]}}, x_q} : {{XW{1'b0}}, x_q};
        y_ext = tc ? {{XW{y_q[OPW-1]}}, y_q} : {{XW{1'b0}}, y_q};
        mul   = x_ext * y_ext;
    end

    generate
        if (OPW > 1) begin : g_rnd
            assign rnd_term = {{(AW-1){1'b0}}, rnd} << (OPW-1);
        end else begin : g_rnd1
            assign rnd_term = {{(AW-1){1'b0}}, rnd};
        end
    endgenerate

    assign prod = mul + rnd_term;

endmodule

// File: rtl/mac_accum.sv
`timescale 1ns/1ps
module mac_accum
    import mac_pkg::*;
#(
    parameter int AW = 35
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_p,
    input  acc_op_t       op,
    input  logic [AW-1:0] prod,
    input  logic [AW-1:0] pre_data,
    output logic [AW-1:0] acc_q
);

    logic [AW-1:0] acc_nxt;

    always_comb begin
        unique case (op)
            OP_LOAD:    acc_nxt = prod;
            OP_ADD:     acc_nxt = prod + acc_q;
            OP_SUBR:    acc_nxt = prod - acc_q;
            OP_PRELOAD: acc_nxt = pre_data;
            default:    acc_nxt = prod;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (ld_p)
            acc_q <= acc_nxt;
    end

endmodule

// File: rtl/mac_preload_top.sv
`timescale 1ns/1ps
module mac_preload_top
    import mac_pkg::*;
#(
    parameter int OPW = 16,
    parameter int GW  = 3,
    localparam int AW = 2*OPW + GW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_x,
    input  logic            ld_y,
    input  logic            ld_p,
    input  logic [OPW-1:0]  x_in,
    input  logic [OPW-1:0]  y_in,
    input  logic            tc_in,
    input  logic            rnd_in,
    input  logic            acc_in,
    input  logic            sub_in,
    input  logic            prel,
    input  logic [AW-1:0]   pre_data,
    output logic [GW-1:0]   ext_o,
    output logic [OPW-1:0]  msp_o,
    output logic [OPW-1:0]  lsp_o
);

    mac_ctrl_t       ctrl_in;
    mac_ctrl_t       ctrl_q;
    logic [OPW-1:0]  x_q;
    logic [OPW-1:0]  y_q;
    logic [AW-1:0]   prod;
    logic [AW-1:0]   acc_q;
    acc_op_t         op;

    always_comb begin
        ctrl_in.tc  = tc_in;
        ctrl_in.rnd = rnd_in;
        ctrl_in.acc = acc_in;
        ctrl_in.sub = sub_in;
    end

    mac_in_regs #(.OPW(OPW)) u_in (
        .clk     (clk),
        .rst     (rst),
        .ld_x    (ld_x),
        .ld_y    (ld_y),
        .x_in    (x_in),
        .y_in    (y_in),
        .ctrl_in (ctrl_in),
        .x_q     (x_q),
        .y_q     (y_q),
        .ctrl_q  (ctrl_q)
    );

    mac_product #(.OPW(OPW), .GW(GW)) u_mul (
        .x_q  (x_q),
        .y_q  (y_q),
        .tc   (ctrl_q.tc),
        .rnd  (ctrl_q.rnd),
        .prod (prod)
    );

    assign op = decode_op(prel, ctrl_q);

    mac_accum #(.AW(AW)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .ld_p     (ld_p),
        .op       (op),
        .prod     (prod),
        .pre_data (pre_data),
        .acc_q    (acc_q)
    );

    assign ext_o = acc_q[AW-1 -: GW];
    assign msp_o = acc_q[2*OPW-1 -: OPW];
    assign lsp_o = acc_q[OPW-1:0];

endmodule

// File: rtl/mac_preload_chk.sv
`timescale 1ns/1ps
module mac_preload_chk
    import mac_pkg::*;
#(
    parameter int AW = 35
) (
    input logic          clk,
    input logic          rst,
    input logic          ld_x,
    input logic          ld_y,
    input logic          ld_p,
    input logic          prel,
    input logic [AW-1:0] pre_data,
    input mac_ctrl_t     ctrl_in,
    input mac_ctrl_t     ctrl_q,
    input logic [AW-1:0] prod,
    input logic [AW-1:0] acc_q
);

    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        if (rst_q)
            p_reset_zero_r1: assert (acc_q == '0 && ctrl_q == '0);
        rst_q <= rst;
    end

    p_hold_acc_r10: assert property (@(posedge clk) disable iff (rst)
        !ld_p |=> $stable(acc_q));

    p_preload_r8: assert property (@(posedge clk) disable iff (rst)
        (ld_p && prel) |=> acc_q == $past(pre_data));

    p_load_prod_r8: assert property (@(posedge clk) disable iff (rst)
        (ld_p && !prel && !ctrl_q.acc) |=> acc_q == $past(prod));

    p_add_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_p && !prel && ctrl_q.acc && !ctrl_q.sub)
        |=> acc_q == AW'($past(prod) + $past(acc_q)));

    p_subr_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_p && !prel && ctrl_q.acc && ctrl_q.sub)
        |=> acc_q == AW'($past(prod) - $past(acc_q)));

    p_ctrl_capture_r9: assert property (@(posedge clk) disable iff (rst)
        (ld_x || ld_y) |=> ctrl_q == $past(ctrl_in));

    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ld_x && !ld_y) |=> $stable(ctrl_q));

endmodule

bind mac_preload_top mac_preload_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ld_x     (ld_x),
    .ld_y     (ld_y),
    .ld_p     (ld_p),
    .prel     (prel),
    .pre_data (pre_data),
    .ctrl_in  (ctrl_in),
    .ctrl_q   (ctrl_q),
    .prod     (prod),
    .acc_q    (acc_q)
);

// File: tb/sim_mac_preload_top.sv
`timescale 1ns/1ps
module sim_mac_preload_top;

    localparam int W  = 4;
    localparam int G  = 3;
    localparam int AW = 2*W + G;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_x = 1'b0, ld_y = 1'b0, ld_p = 1'b0;
    logic [W-1:0]  x_in = '0, y_in = '0;
    logic          tc_in = 1'b0, rnd_in = 1'b0, acc_in = 1'b0, sub_in = 1'b0;
    logic          prel = 1'b0;
    logic [AW-1:0] pre_data = '0;
    logic [G-1:0]  ext_o;
    logic [W-1:0]  msp_o, lsp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    mac_preload_top #(.OPW(W), .GW(G)) u0 (
        .clk(clk), .rst(rst), .ld_x(ld_x), .ld_y(ld_y), .ld_p(ld_p),
        .x_in(x_in), .y_in(y_in), .tc_in(tc_in), .rnd_in(rnd_in),
        .acc_in(acc_in), .sub_in(sub_in), .prel(prel), .pre_data(pre_data),
        .ext_o(ext_o), .msp_o(msp_o), .lsp_o(lsp_o)
    );

    always #2.5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] mdl(bit tc, bit rnd, bit acc, bit sub,
                                          int x, int y, logic [AW-1:0] a);
        longint sx, sy, p, r;
        logic [63:0] t;
        sx = (tc && x >= 2**(W-1)) ? longint'(x - 2**W) : longint'(x);
        sy = (tc && y >= 2**(W-1)) ? longint'(y - 2**W) : longint'(y);
        p  = sx * sy + (rnd ? longint'(2**(W-1)) : 0);
        if (!acc)     r = p;
        else if (sub) r = p - longint'(a);
        else          r = p + longint'(a);
        t = r;
        return t[AW-1:0];
    endfunction

    task automatic check(string req, logic [AW-1:0] exp);
        logic [AW-1:0] act;
        act = {ext_o, msp_o, lsp_o};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        ld_x = 0; ld_y = 0; ld_p = 0; prel = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [AW-1:0] pv;
        logic [AW-1:0] exp;
        idle();
        tick(); tick();
        rst = 0;
        check("R1 reset", '0);

        // R2: field split, checked per field
        prel = 1; ld_p = 1; pre_data = {3'b101, 4'h9, 4'h3};
        tick(); idle();
        n_chk++;
        if (ext_o !== 3'b101 || msp_o !== 4'h9 || lsp_o !== 4'h3) begin
            n_bad++;
            $display("FAIL R2 fields: actual %b/%h/%h expected 101/9/3", ext_o, msp_o, lsp_o);
        end

        // R3 R4 R5 R11: plain loads over all operand pairs
        for (int tc = 0; tc < 2; tc++)
            for (int rd = 0; rd < 2; rd++)
                for (int x = 0; x < 2**W; x++)
                    for (int y = 0; y < 2**W; y++) begin
                        ld_x = 1; ld_y = 1; x_in = W'(x); y_in = W'(y);
                        tc_in = tc[0]; rnd_in = rd[0]; acc_in = 0; sub_in = x[1];
                        tick(); idle();
                        ld_p = 1;
                        tick(); idle();
                        check(tc != 0 ? (rd != 0 ? "R4 R5 signed round" : "R4 signed")
                                      : (rd != 0 ? "R3 R5 unsigned round" : "R3 unsigned"),
                              mdl(tc[0], rd[0], 1'b0, 1'b0, x, y, '0));
                    end

        // R6 R7 R8 R11: preload, then accumulate in either direction
        for (int tc = 0; tc < 2; tc++)
            for (int sb = 0; sb < 2; sb++)
                for (int x = 0; x < 2**W; x++)
                    for (int y = 0; y < 2**W; y++) begin
                        pv = AW'(x * 151 + y * 37 + tc * 1021 + sb * 613);
                        ld_x = 1; ld_y = 1; x_in = W'(x); y_in = W'(y);
                        tc_in = tc[0]; rnd_in = x[0]; acc_in = 1; sub_in = sb[0];
                        ld_p = 1; prel = 1; pre_data = pv;
                        tick(); idle();
                        check("R8 preload", pv);
                        ld_p = 1;
                        tick(); idle();
                        check(sb != 0 ? "R7 R11 subtract" : "R6 R11 add",
                              mdl(tc[0], x[0], 1'b1, sb[0], x, y, pv));
                    end

        // R9: capture through ld_y alone, then hold with both strobes low
        ld_x = 1; x_in = 4'd5; tc_in = 0; rnd_in = 0; acc_in = 1; sub_in = 1;
        tick(); idle();
        ld_y = 1; y_in = 4'd3; acc_in = 0; sub_in = 0;
        tick(); idle();
        tc_in = 1; rnd_in = 1; acc_in = 1; sub_in = 1;
        ld_p = 1; prel = 1; pre_data = 11'h123;
        tick(); idle();
        ld_p = 1;
        tick(); idle();
        check("R9 ld_y capture and hold", mdl(1'b0, 1'b0, 1'b0, 1'b0, 5, 3, '0));
        // R9: capture through ld_x alone
        ld_x = 1; x_in = 4'd13; tc_in = 1; rnd_in = 1; acc_in = 0; sub_in = 0;
        tick(); idle();
        ld_p = 1;
        tick(); idle();
        check("R9 ld_x capture", mdl(1'b1, 1'b1, 1'b0, 1'b0, 13, 3, '0));

        // R10: no ld_p, outputs hold while everything else moves
        exp = mdl(1'b1, 1'b1, 1'b0, 1'b0, 13, 3, '0);
        for (int k = 0; k < 6; k++) begin
            ld_x = 1; ld_y = 1; x_in = W'(k); y_in = W'(k + 7);
            prel = 1; pre_data = AW'(k * 99); acc_in = k[0]; sub_in = 1;
            tick(); idle();
            check("R10 hold", exp);
        end

        // R12: same-edge operand and product load uses old registers
        ld_x = 1; ld_y = 1; x_in = 4'd6; y_in = 4'd7;
        tc_in = 0; rnd_in = 0; acc_in = 0; sub_in = 0;
        tick(); idle();
        ld_x = 1; ld_y = 1; ld_p = 1; x_in = 4'd15; y_in = 4'd15;
        tc_in = 1; rnd_in = 1; acc_in = 1; sub_in = 1;
        tick(); idle();
        check("R12 same edge old operands", AW'(42));
        ld_p = 1;
        tick(); idle();
        check("R12 next edge new operands", mdl(1'b1, 1'b1, 1'b1, 1'b1, 15, 15, AW'(42)));

        // R1: reset in mid-run
        rst = 1;
        tick();
        rst = 0;
        check("R1 reset again", '0);

        finish_run();
    end

endmodule